// File: doc/BRIEF.md
# Virtually Indexed, Physically Tagged L1 Data Cache

This block is the lookup and refill part of a set-associative first-level data cache. The set is chosen from address bits that address translation never changes, so the tag and data arrays are read in the same cycle the load is accepted. The translation unit works on the upper address bits in parallel. The tag comparison in the next cycle uses the physical page number from the translation unit. Two virtual names for one physical line therefore always select the same set and compare against the same tag. Switching address spaces needs no flush.

Capacity per way can never exceed one page. The default geometry uses 16 KiB pages, 64-byte lines (256 sets) and 8 ways, for 128 KiB in total. A parameter set whose line offset plus set index would reach beyond the page offset is rejected at elaboration.

On a miss, the cache asks for the whole physical line. It writes the line into a victim way, chosen first among invalid ways and otherwise by a per-set tree pseudo-LRU. It then repeats the lookup internally. A global invalidate walks through the sets, one per cycle.

Top module: `vipt_l1d_cache`

## Requirements
- R1: Elaboration fails unless log2(line bytes) + log2(sets) <= log2(page bytes); with defaults every way holds one full page, so lines in set 0 and set SETS-1 coexist.
- R2: Set index is vaddr[6 +: 8] and word select is vaddr[3 +: 3]; vaddr bits 14 and above and bits 2:0 have no effect on the lookup.
- R3: A load accepted at edge k with xlat_valid high in cycle k+1 and a matching valid tag gives resp_valid=1, resp_hit=1 in cycle k+1, with resp_data equal to 64-bit word vaddr[5:3] of the line (word w is fill_data[64*w +: 64]).
- R4: While translation is not valid in the compare cycle, resp_valid, fill_req_valid and req_ready all stay low.
- R5: A miss raises fill_req_valid in the following cycle with fill_req_addr = {ppn, vaddr[13:6]}. The request stays high and steady until fill_valid is seen.
- R6: Two cycles after the cycle in which fill_valid is accepted, the replayed load responds with resp_valid=1, resp_hit=0 and the requested word of the filled line.
- R7: The victim is the lowest-numbered invalid way. If all ways are valid, a per-set tree of WAYS-1 bits chooses it: node 0 is the root, node n has children 2n+1 (value 0) and 2n+2 (value 1), and the way number is the path read from the most significant bit down. Every hit and every fill makes each node on the accessed way's path point to the other child. All bits are zero after reset.
- R8: The tag is the physical page number. The same virtual address with a different page number misses, and the earlier line stays resident without any flush.
- R9: A global invalidate holds req_ready low for exactly SETS cycles. Afterwards every line misses, and the replacement trees keep their state.
- R10: When inv_start and req_valid are high together in the idle state, the invalidate wins and the load is not accepted.
- R11: req_ready is high only when idle. It drops after a load is accepted and stays low until that load has responded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Load request present |
| req_ready | output | 1 | Load can be accepted this cycle |
| req_vaddr | input | VA_W | Virtual address of the load |
| xlat_valid | input | 1 | Translation result valid |
| xlat_ppn | input | PA_W-14 | Physical page number from the translation unit |
| fill_req_valid | output | 1 | Line refill requested |
| fill_req_addr | output | PA_W-6 | Physical line address of the refill |
| fill_valid | input | 1 | Refill line present |
| fill_data | input | 512 | Refill line, word w in bits 64*w +: 64 |
| resp_valid | output | 1 | Load response |
| resp_hit | output | 1 | Response came from a hit without a refill |
| resp_data | output | 64 | Loaded word |
| inv_start | input | 1 | Start a global invalidate |

## Verification
The bench goes after three groups of cases. The first is aliasing and address-space changes: one physical line reached through different upper virtual bits, and one virtual offset reached with different page numbers. A design that indexed with translated bits, or tagged with virtual bits, would return the wrong line or miss when it should hit. The second is replacement pressure on a few hot sets with more page numbers than ways. A wrong tree walk or update shows up as an unexpected hit or miss against the bench's own model. The third is timing: translation stalls, delayed refills, the replay position, and an invalidate that arrives together with a load. A design that respected neither the stall nor the invalidate priority would answer early, answer twice, or keep stale lines.

// File: rtl/vipt_pkg.sv
// Shared types for the VIPT L1 data cache.
package vipt_pkg;
    // Controller states: idle, tag compare, waiting for refill, replay read, invalidate walk.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOK,
        ST_MISS,
        ST_RERD,
        ST_INV
    } cstate_e;
endpackage

// File: rtl/vipt_plru.sv
// Per-set tree pseudo-LRU. Holds WAYS-1 bits per set. Node 0 is the root,
// and node n has children 2n+1 (bit 0) and 2n+2 (bit 1).
// Assumes WAYS is a power of two, at least 2.
module vipt_plru #(
    parameter int SETS = 256,
    parameter int WAYS = 8,
    localparam int IDX_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS),
    localparam int NB = WAYS - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] set_sel,
    output logic [WAY_W-1:0] victim,
    input  logic             touch_en,
    input  logic [WAY_W-1:0] touch_way
);
    logic [NB-1:0] tree_q [SETS];
    logic [NB-1:0] cur;
    logic [NB-1:0] nxt;

    assign cur = tree_q[set_sel];

    // Walk the tree from the root to find the replacement way.
    always_comb begin
        logic [WAY_W-1:0] node;
        victim = '0;
        node   = '0;
        for (int l = 0; l < WAY_W; l++) begin
            victim = WAY_W'((32'(victim) << 1) | 32'(cur[node]));
            node   = WAY_W'((32'(node) << 1) + 32'd1 + 32'(cur[node]));
        end
    end

    // Point every node on the touched way's path to the other side.
    always_comb begin
        logic [WAY_W-1:0] node;
        nxt  = cur;
        node = '0;
        for (int l = 0; l < WAY_W; l++) begin
            nxt[node] = ~touch_way[WAY_W-1-l];
            node = WAY_W'((32'(node) << 1) + 32'd1 + 32'(touch_way[WAY_W-1-l]));
        end
    end

    // Tree state register: cleared at reset, updated on a touch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) tree_q[s] <= '0;
        end else if (touch_en) begin
            tree_q[set_sel] <= nxt;
        end
    end
endmodule

// File: rtl/vipt_arrays.sv
// Tag, valid and data storage for all ways. A read returns the valid
// bits, the physical tags and one selected word of each way of a set in
// the following cycle. A fill writes one way's line. An invalidate clears
// the valid bits of one set.
// Assumes the controller never reads and writes in the same cycle.
module vipt_arrays #(
    parameter int SETS = 256,
    parameter int WAYS = 8,
    parameter int TAG_W = 26,
    parameter int WORDS = 8,
    parameter int WORD_BITS = 64,
    localparam int IDX_W = $clog2(SETS),
    localparam int WSEL_W = $clog2(WORDS)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            rd_en,
    input  logic [IDX_W-1:0]                rd_set,
    input  logic [WSEL_W-1:0]               rd_wsel,
    output logic [WAYS-1:0]                 rd_valid,
    output logic [WAYS-1:0][TAG_W-1:0]      rd_tag,
    output logic [WAYS-1:0][WORD_BITS-1:0]  rd_word,
    input  logic                            wr_en,
    input  logic [IDX_W-1:0]                wr_set,
    input  logic [WAYS-1:0]                 wr_way_oh,
    input  logic [TAG_W-1:0]                wr_tag,
    input  logic [WORDS-1:0][WORD_BITS-1:0] wr_line,
    output logic [WAYS-1:0]                 set_valid,
    input  logic                            inv_en,
    input  logic [IDX_W-1:0]                inv_set
);
    logic [WAYS-1:0]                 valid_q  [SETS];
    logic [TAG_W-1:0]                tag_mem  [SETS][WAYS];
    logic [WORDS-1:0][WORD_BITS-1:0] data_mem [SETS][WAYS];

    assign set_valid = valid_q[wr_set];

    // Valid bits: cleared at reset or by the invalidate walk, set on a fill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) valid_q[s] <= '0;
        end else if (inv_en) begin
            valid_q[inv_set] <= '0;
        end else if (wr_en) begin
            valid_q[wr_set] <= valid_q[wr_set] | wr_way_oh;
        end
    end

    // Tag and data arrays: write the selected way on a fill.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            for (int w = 0; w < WAYS; w++) begin
                if (wr_way_oh[w]) begin
                    tag_mem[wr_set][w]  <= wr_tag;
                    data_mem[wr_set][w] <= wr_line;
                end
            end
        end
    end

    // Registered read of every way of one set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= '0;
            rd_tag   <= '0;
            rd_word  <= '0;
        end else if (rd_en) begin
            rd_valid <= valid_q[rd_set];
            for (int w = 0; w < WAYS; w++) begin
                rd_tag[w]  <= tag_mem[rd_set][w];
                rd_word[w] <= data_mem[rd_set][w][rd_wsel];
            end
        end
    end
endmodule

// File: rtl/vipt_l1d_cache.sv
// Top of the VIPT L1 data cache. The arrays are read from page-offset bits
// when a load is accepted. The next cycle compares the stored physical tags
// with the translated page number. A miss requests the physical line, fills
// a victim way and replays the lookup. A global invalidate clears one set
// per cycle.
// Assumes one load in flight and a translation result held until it is used.
module vipt_l1d_cache
    import vipt_pkg::*;
#(
    parameter int VA_W = 48,
    parameter int PA_W = 40,
    parameter int PAGE_BYTES = 16384,
    parameter int LINE_BYTES = 64,
    parameter int SETS = 256,
    parameter int WAYS = 8,
    parameter int WORD_BITS = 64,
    localparam int PAGE_OFF_W = $clog2(PAGE_BYTES),
    localparam int OFF_W = $clog2(LINE_BYTES),
    localparam int IDX_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS),
    localparam int BSEL_W = $clog2(WORD_BITS / 8),
    localparam int WORDS = LINE_BYTES * 8 / WORD_BITS,
    localparam int WSEL_W = $clog2(WORDS),
    localparam int PPN_W = PA_W - PAGE_OFF_W,
    localparam int LADDR_W = PA_W - OFF_W,
    localparam int LINE_BITS = LINE_BYTES * 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [VA_W-1:0]      req_vaddr,
    input  logic                 xlat_valid,
    input  logic [PPN_W-1:0]     xlat_ppn,
    output logic                 fill_req_valid,
    output logic [LADDR_W-1:0]   fill_req_addr,
    input  logic                 fill_valid,
    input  logic [LINE_BITS-1:0] fill_data,
    output logic                 resp_valid,
    output logic                 resp_hit,
    output logic [WORD_BITS-1:0] resp_data,
    input  logic                 inv_start
);
    // Geometry rule: one way must fit inside the untranslated page offset.
    if (OFF_W + IDX_W > PAGE_OFF_W) begin : g_geom_bad
        $error("vipt_l1d_cache: line offset plus set index exceeds page offset");
    end

    cstate_e                        state_q;
    logic [PAGE_OFF_W-1:0]          off_q;
    logic [PPN_W-1:0]               ppn_q;
    logic                           replay_q;
    logic [IDX_W-1:0]               inv_cnt_q;
    logic [IDX_W-1:0]               set_q;
    logic [WSEL_W-1:0]              wsel_q;
    logic                           accept;
    logic                           rd_en;
    logic [IDX_W-1:0]               rd_set;
    logic [WSEL_W-1:0]              rd_wsel;
    logic [WAYS-1:0]                rd_valid;
    logic [WAYS-1:0][PPN_W-1:0]     rd_tag;
    logic [WAYS-1:0][WORD_BITS-1:0] rd_word;
    logic [WAYS-1:0]                set_valid;
    logic [PPN_W-1:0]               look_ppn;
    logic                           go;
    logic [WAYS-1:0]                hit_vec;
    logic                           hit;
    logic [WAY_W-1:0]               hit_way;
    logic [WAY_W-1:0]               plru_way;
    logic [WAY_W-1:0]               victim;
    logic                           fill_en;
    logic [WAYS-1:0]                wr_way_oh;
    logic                           unused_va;

    assign unused_va = ^{req_vaddr[VA_W-1:PAGE_OFF_W], req_vaddr[BSEL_W-1:0]};
    assign set_q     = off_q[OFF_W +: IDX_W];
    assign wsel_q    = off_q[BSEL_W +: WSEL_W];

    // Handshake: loads are accepted only when idle and no invalidate is asked for.
    assign req_ready = (state_q == ST_IDLE) && !inv_start;
    assign accept    = req_ready && req_valid;

    // Array read: page-offset bits of the new load, or the held set on replay.
    assign rd_en   = accept || (state_q == ST_RERD);
    assign rd_set  = (state_q == ST_IDLE) ? req_vaddr[OFF_W +: IDX_W] : set_q;
    assign rd_wsel = (state_q == ST_IDLE) ? req_vaddr[BSEL_W +: WSEL_W] : wsel_q;

    // Tag compare against the physical page number.
    assign look_ppn = replay_q ? ppn_q : xlat_ppn;
    assign go       = (state_q == ST_LOOK) && (replay_q || xlat_valid);
    always_comb begin
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            hit_vec[w] = rd_valid[w] && (rd_tag[w] == look_ppn);
            if (hit_vec[w]) hit_way = WAY_W'(w);
        end
        hit = |hit_vec;
    end

    // Response outputs.
    assign resp_valid = go && hit;
    assign resp_hit   = !replay_q;
    assign resp_data  = resp_valid ? rd_word[hit_way] : '0;

    // Refill request and victim choice: lowest invalid way first, else the tree.
    assign fill_req_valid = (state_q == ST_MISS);
    assign fill_req_addr  = {ppn_q, off_q[PAGE_OFF_W-1:OFF_W]};
    assign fill_en        = fill_req_valid && fill_valid;
    always_comb begin
        victim = plru_way;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!set_valid[w]) victim = WAY_W'(w);
        end
        for (int w = 0; w < WAYS; w++) wr_way_oh[w] = fill_en && (victim == WAY_W'(w));
    end

    // Controller state and the held load context.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            off_q     <= '0;
            ppn_q     <= '0;
            replay_q  <= 1'b0;
            inv_cnt_q <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (inv_start) begin
                        state_q   <= ST_INV;
                        inv_cnt_q <= '0;
                    end else if (req_valid) begin
                        state_q  <= ST_LOOK;
                        off_q    <= req_vaddr[PAGE_OFF_W-1:0];
                        replay_q <= 1'b0;
                    end
                end
                ST_LOOK: begin
                    if (go) begin
                        if (hit) begin
                            state_q <= ST_IDLE;
                        end else begin
                            state_q <= ST_MISS;
                            ppn_q   <= xlat_ppn;
                        end
                    end
                end
                ST_MISS: if (fill_valid) state_q <= ST_RERD;
                ST_RERD: begin
                    state_q  <= ST_LOOK;
                    replay_q <= 1'b1;
                end
                ST_INV: begin
                    inv_cnt_q <= inv_cnt_q + 1'b1;
                    if (inv_cnt_q == IDX_W'(SETS - 1)) state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    vipt_arrays #(
        .SETS(SETS), .WAYS(WAYS), .TAG_W(PPN_W), .WORDS(WORDS), .WORD_BITS(WORD_BITS)
    ) u_arrays (
        .clk(clk), .rst_n(rst_n),
        .rd_en(rd_en), .rd_set(rd_set), .rd_wsel(rd_wsel),
        .rd_valid(rd_valid), .rd_tag(rd_tag), .rd_word(rd_word),
        .wr_en(fill_en), .wr_set(set_q), .wr_way_oh(wr_way_oh), .wr_tag(ppn_q),
        .wr_line(fill_data), .set_valid(set_valid),
        .inv_en(state_q == ST_INV), .inv_set(inv_cnt_q)
    );

    vipt_plru #(.SETS(SETS), .WAYS(WAYS)) u_plru (
        .clk(clk), .rst_n(rst_n), .set_sel(set_q), .victim(plru_way),
        .touch_en(resp_valid || fill_en),
        .touch_way(fill_en ? victim : hit_way)
    );
endmodule

// File: rtl/vipt_l1d_checker.sv
// Protocol and storage assertions for vipt_l1d_cache, attached by bind.
module vipt_l1d_checker #(
    parameter int WAYS = 8,
    parameter int LADDR_W = 34
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               req_ready,
    input logic               xlat_valid,
    input logic               fill_req_valid,
    input logic [LADDR_W-1:0] fill_req_addr,
    input logic               fill_valid,
    input logic               resp_valid,
    input logic               resp_hit,
    input logic               inv_start,
    input logic               in_look,
    input logic               in_inv,
    input logic               replay,
    input logic [WAYS-1:0]    hit_vec,
    input logic [WAYS-1:0]    wr_way_oh
);
    // R11: an accepted load keeps the port closed in the next cycle.
    a_r11_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);
    // R11: no new load is taken in the cycle that answers one.
    a_r11_closed_on_resp: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> !req_ready);
    // R10: an invalidate request closes the load port.
    a_r10_inv_first: assert property (@(posedge clk) disable iff (!rst_n)
        inv_start |-> !req_ready);
    // R9: the invalidate walk is silent on every other output.
    a_r9_inv_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        in_inv |-> (!req_ready && !resp_valid && !fill_req_valid));
    // R4: no answer and no refill without a translation.
    a_r4_stall_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (in_look && !replay && !xlat_valid) |-> (!resp_valid && !fill_req_valid && !req_ready));
    // R5: the refill request holds its address until it is served.
    a_r5_fill_held: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_req_valid && !fill_valid) |=> (fill_req_valid && $stable(fill_req_addr)));
    // R6: the replay answers two cycles after the fill, as a non-hit.
    a_r6_replay_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_req_valid && fill_valid) |=> !resp_valid ##1 (resp_valid && !resp_hit));
    // R7: a fill writes at most one way.
    a_r7_one_way: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_way_oh));
    // R8: one physical tag is never resident twice in a set.
    a_r8_unique_tag: assert property (@(posedge clk) disable iff (!rst_n)
        in_look |-> $onehot0(hit_vec));
endmodule

bind vipt_l1d_cache vipt_l1d_checker #(.WAYS(WAYS), .LADDR_W(LADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .xlat_valid(xlat_valid), .fill_req_valid(fill_req_valid),
    .fill_req_addr(fill_req_addr), .fill_valid(fill_valid),
    .resp_valid(resp_valid), .resp_hit(resp_hit), .inv_start(inv_start),
    .in_look(state_q == vipt_pkg::ST_LOOK), .in_inv(state_q == vipt_pkg::ST_INV),
    .replay(replay_q), .hit_vec(hit_vec), .wr_way_oh(wr_way_oh)
);

// File: tb/sim_vipt_l1d_cache.sv
// Self-checking bench: directed corner cases plus seeded random loads,
// compared against a bench model of tags, valid bits and replacement trees.
module sim_vipt_l1d_cache;
    localparam int SETS = 256;
    localparam int WAYS = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic [47:0]  req_vaddr = '0;
    logic         xlat_valid = 1'b0;
    logic [25:0]  xlat_ppn = '0;
    logic         fill_req_valid;
    logic [33:0]  fill_req_addr;
    logic         fill_valid = 1'b0;
    logic [511:0] fill_data = '0;
    logic         resp_valid;
    logic         resp_hit;
    logic [63:0]  resp_data;
    logic         inv_start = 1'b0;

    int checks = 0;
    int fails  = 0;

    bit          mvalid [SETS][WAYS];
    logic [25:0] mtag   [SETS][WAYS];
    logic [6:0]  mtree  [SETS];

    always #4 clk = ~clk;

    vipt_l1d_cache #(
        .VA_W(48), .PA_W(40), .PAGE_BYTES(16384), .LINE_BYTES(64),
        .SETS(SETS), .WAYS(WAYS), .WORD_BITS(64)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .xlat_valid(xlat_valid), .xlat_ppn(xlat_ppn),
        .fill_req_valid(fill_req_valid), .fill_req_addr(fill_req_addr),
        .fill_valid(fill_valid), .fill_data(fill_data), .resp_valid(resp_valid),
        .resp_hit(resp_hit), .resp_data(resp_data), .inv_start(inv_start)
    );

    function automatic logic [63:0] word_of(logic [33:0] la, int w);
        return {6'h2A, la, 21'h0, 3'(w)};
    endfunction

    function automatic logic [511:0] line_of(logic [33:0] la);
        logic [511:0] l;
        for (int w = 0; w < 8; w++) l[w*64 +: 64] = word_of(la, w);
        return l;
    endfunction

    function automatic int tree_victim(logic [6:0] t);
        int node = 0;
        int v = 0;
        for (int l = 0; l < 3; l++) begin
            v = v * 2 + int'(t[node]);
            node = 2 * node + 1 + int'(t[node]);
        end
        return v;
    endfunction

    function automatic logic [6:0] tree_touch(logic [6:0] t, int way);
        int node = 0;
        for (int l = 0; l < 3; l++) begin
            int d = (way >> (2 - l)) & 1;
            t[node] = (d == 0);
            node = 2 * node + 1 + d;
        end
        return t;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_load(input logic [47:0] va, input logic [25:0] ppn, input int xdly, input int fdly);
        int set = int'(va[13:6]);
        int ws = int'(va[5:3]);
        logic [33:0] la = {ppn, va[13:6]};
        int hw = -1;
        int n = 0;
        int fill_at = -1;
        int resp_at = -1;
        int fw = 0;
        bit filled = 0;
        logic got_hit = 1'b0;
        logic [63:0] got_data = '0;
        logic [33:0] seen = '0;
        for (int w = 0; w < WAYS; w++) if (mvalid[set][w] && mtag[set][w] == ppn) hw = w;
        @(negedge clk);
        req_valid = 1'b1;
        req_vaddr = va;
        #1;
        chk(req_ready == 1'b1, "R11 ready when idle", 64'(req_ready), 64'd1);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < xdly; i++) begin
            #1;
            chk(!req_ready && !resp_valid && !fill_req_valid, "R4 quiet while untranslated",
                64'({req_ready, resp_valid, fill_req_valid}), 64'd0);
            @(negedge clk);
        end
        xlat_valid = 1'b1;
        xlat_ppn = ppn;
        while (resp_at < 0 && n < 64) begin
            #1;
            if (resp_valid) begin
                resp_at = n;
                got_hit = resp_hit;
                got_data = resp_data;
            end else if (fill_req_valid && !filled) begin
                if (fw == fdly) begin
                    seen = fill_req_addr;
                    fill_data = line_of(fill_req_addr);
                    fill_valid = 1'b1;
                    filled = 1;
                    fill_at = n;
                end else begin
                    fw++;
                end
            end
            @(negedge clk);
            fill_valid = 1'b0;
            n++;
        end
        xlat_valid = 1'b0;
        chk(resp_at >= 0, "R3 response arrives", 64'(resp_at), 64'd0);
        chk(got_hit == (hw >= 0), "R3 hit flag", 64'(got_hit), 64'(hw >= 0));
        chk(got_data == word_of(la, ws), "R3 returned word", got_data, word_of(la, ws));
        if (hw >= 0) begin
            chk(resp_at == 0, "R3 one-cycle hit", 64'(resp_at), 64'd0);
            mtree[set] = tree_touch(mtree[set], hw);
        end else begin
            int v = -1;
            chk(filled && seen == la, "R5 refill line address", 64'(seen), 64'(la));
            chk(resp_at == fill_at + 2, "R6 replay two cycles after fill", 64'(resp_at), 64'(fill_at + 2));
            for (int w = WAYS - 1; w >= 0; w--) if (!mvalid[set][w]) v = w;
            if (v < 0) v = tree_victim(mtree[set]);
            mvalid[set][v] = 1;
            mtag[set][v] = ppn;
            mtree[set] = tree_touch(mtree[set], v);
        end
    endtask

    task automatic do_inv(input bit with_req);
        int n = 0;
        @(negedge clk);
        inv_start = 1'b1;
        req_valid = with_req;
        req_vaddr = {34'h7, 8'd3, 6'h0};
        #1;
        chk(!req_ready, "R10 load port closed by invalidate", 64'(req_ready), 64'd0);
        @(posedge clk);
        @(negedge clk);
        inv_start = 1'b0;
        req_valid = 1'b0;
        #1;
        while (!req_ready && n < SETS + 8) begin
            if (resp_valid || fill_req_valid)
                chk(0, "R9 silent invalidate", 64'({resp_valid, fill_req_valid}), 64'd0);
            n++;
            @(negedge clk);
            #1;
        end
        chk(n == SETS, with_req ? "R10 load dropped, walk of SETS cycles" : "R9 walk of SETS cycles",
            64'(n), 64'(SETS));
        for (int s = 0; s < SETS; s++) for (int w = 0; w < WAYS; w++) mvalid[s][w] = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        int seed_sink;
        for (int s = 0; s < SETS; s++) begin
            mtree[s] = '0;
            for (int w = 0; w < WAYS; w++) begin
                mvalid[s][w] = 0;
                mtag[s][w] = '0;
            end
        end
        seed_sink = int'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(req_ready && !resp_valid && !fill_req_valid, "R11 reset state",
            64'({req_ready, resp_valid, fill_req_valid}), 64'b100);

        // R5 R6: cold miss with refill and replay, then R3: hit on the same line.
        do_load({34'h1, 8'd3, 6'h18}, 26'h0AB, 0, 0);
        do_load({34'h1, 8'd3, 6'h18}, 26'h0AB, 0, 0);
        // R2: other upper virtual bits, same physical page: a synonym hits.
        do_load({34'h2DEAD, 8'd3, 6'h08}, 26'h0AB, 0, 0);
        // R8: same virtual address, new address space: miss, old line kept.
        do_load({34'h1, 8'd3, 6'h18}, 26'h0AC, 0, 2);
        do_load({34'h9, 8'd3, 6'h38}, 26'h0AB, 0, 0);
        // R1: the last set of the page coexists with set 3.
        do_load({34'h5, 8'd255, 6'h38}, 26'h0AB, 0, 1);
        do_load({34'h5, 8'd3, 6'h00}, 26'h0AB, 0, 0);
        // R7: fill set 5 past its ways, then revisit every page.
        for (int p = 0; p < 10; p++) do_load({34'h3, 8'd5, 6'h10}, 26'h300 + 26'(p), 0, 0);
        for (int p = 0; p < 10; p++) do_load({34'h4, 8'd5, 6'h20}, 26'h300 + 26'(p), 0, 0);
        // R4: translation arrives late.
        do_load({34'h6, 8'd3, 6'h18}, 26'h0AB, 3, 0);
        do_load({34'h6, 8'd77, 6'h18}, 26'h0AB, 2, 1);
        // R9: invalidate, then a resident line misses.
        do_inv(0);
        do_load({34'h1, 8'd3, 6'h18}, 26'h0AB, 0, 0);
        // R10: invalidate together with a load.
        do_inv(1);
        do_load({34'h7, 8'd3, 6'h00}, 26'h0AB, 0, 0);

        // Random loads over a few hot sets with more pages than ways (R7 R8).
        for (int i = 0; i < 300; i++) begin
            logic [47:0] va;
            logic [25:0] ppn;
            int xd;
            case ($urandom % 4)
                0: va[13:6] = 8'd0;
                1: va[13:6] = 8'd9;
                2: va[13:6] = 8'd200;
                default: va[13:6] = 8'd255;
            endcase
            va[47:14] = {2'($urandom), 32'($urandom)};
            va[5:0] = 6'($urandom);
            ppn = 26'h1000 + 26'($urandom % 14);
            xd = ($urandom % 4 == 0) ? 1 + int'($urandom % 3) : 0;
            if (i == 150) do_inv(0);
            do_load(va, ppn, xd, int'($urandom % 3));
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule